// File: doc/BRIEF.md
# Indirect PLL Register Programming Sequencer

This block reprograms one pixel-clock synthesizer channel whose control registers can only be reached through a two-register indirect port. The first register holds the target offset together with a write-enable flag. The second register carries one data byte. Software, or a larger control unit, presents a channel number (0 to 3), a post-divider code, extended control bits, a feedback divider value and two control bytes, then pulses `start`.

The sequencer walks a fixed seven-step recipe on a byte bus:

1. It writes the pixel-clock control byte, which holds the synthesizer in reset.
2. It updates the post-divider register with a read-modify-write.
3. It updates the extended control register with a read-modify-write.
4. It stores the feedback divider.
5. It writes a masked copy of the general control byte.
6. It releases the synthesizer reset.
7. It writes the general control byte again, unmodified.

Every bus access waits for `bus_ack`. The sequencer signals completion with a one-cycle `done` pulse.

Read-modify-write steps change only the bits that belong to the selected channel. The other channels keep their settings.

Top module: `pll_reprog_seq`

## Requirements
- R1: An address access (`bus_sel`=0, `bus_we`=1) carries the register offset in bits 7:2, the write-enable flag in bit 1, and 0 in bit 0. A data access uses `bus_sel`=1, with `bus_we`=1 for a write and 0 for a read.
- R2: A register write takes exactly three accesses: address with write enable set, data write, then the same address with write enable clear. A full sequence takes 25 accesses.
- R3: A register read takes two accesses: address with write enable clear, then a data read whose byte is captured on acceptance.
- R4: Registers are visited in this order: control byte at offset 5, post-divider at 6, extended control at 11, feedback divider at 7+channel, general control at 2, control byte at 5, general control at 2. After the sequence the register file holds the values given in R5 to R9.
- R5: The post-divider register keeps all bits except the 2-bit field at bit position 2×channel, which receives the post-divider code.
- R6: The extended control register has bit 4+channel cleared, then the extended bits ORed in. All other bits are kept.
- R7: The feedback divider byte is written unchanged to offset 7+channel.
- R8: The first general control write has bits 0 and 1 cleared and bit 2 set. The final general control write carries the input byte unmodified.
- R9: The first control byte write carries the input unmodified. The release write carries the input with bit 2 (the reset bit) cleared.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_sel`, `bus_we` and `bus_wdata` hold steady. No access advances without `bus_ack`.
- R11: A `start` pulse while `busy` is high is ignored. The running sequence keeps its captured inputs and no second sequence follows.
- R12: After reset, `bus_req`, `busy` and `done` are low. `done` is a one-cycle pulse in the cycle after the last access is accepted, with `busy` already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| chan | input | 2 | Channel to reprogram |
| post_code | input | 2 | Post-divider field code |
| ext_bits | input | 8 | Bits ORed into the extended control register |
| fb_div | input | 8 | Feedback divider value |
| gen_ctl | input | 8 | General control byte |
| vclk_ctl | input | 8 | Pixel-clock control byte (reset bit at 2) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Access request |
| bus_sel | output | 1 | 0 = address register, 1 = data register |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte from the data register |
| bus_ack | input | 1 | Access accepted this cycle |

## Verification
Each channel is first driven with an always-ready bus and all-ones control bytes. This separates correct field masking from spillover into neighbouring channel fields and shows that the general-control override bits are cleared. Random configurations against a register file with random contents then show that the read-modify-write steps keep the unrelated bits. Random ready stalls show that the access payload holds steady and that the access count does not change. A start pulse injected mid-sequence with different inputs distinguishes a latched configuration from one that follows the live inputs.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int OFF_W  = 6;
    localparam int BYTE_W = 8;
    localparam int CH_W   = 2;

    typedef enum logic [2:0] {
        PH_RADDR,
        PH_RDATA,
        PH_WADDR,
        PH_WDATA,
        PH_WCLOSE
    } phase_e;

    typedef enum logic [2:0] {
        ST_VCLK_HOLD,
        ST_POST,
        ST_EXT,
        ST_FB,
        ST_GEN_MASK,
        ST_VCLK_REL,
        ST_GEN_FINAL
    } step_e;

    typedef struct packed {
        logic [CH_W-1:0]   chan;
        logic [1:0]        post;
        logic [BYTE_W-1:0] ext;
        logic [BYTE_W-1:0] fb;
        logic [BYTE_W-1:0] gen;
        logic [BYTE_W-1:0] vclk;
    } cfg_t;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [BYTE_W-1:0] data;
    } bus_word_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [OFF_W-1:0] off,
                                                    input logic wen);
        return {off, wen, 1'b0};
    endfunction

    function automatic logic step_is_rmw(input step_e s);
        return (s == ST_POST) || (s == ST_EXT);
    endfunction

    function automatic logic [BYTE_W-1:0] merge_pair(input logic [BYTE_W-1:0] old,
                                                     input logic [CH_W-1:0] ch,
                                                     input logic [1:0] code);
        logic [BYTE_W-1:0] msk;
        msk = 8'h03 << {ch, 1'b0};
        return (old & ~msk) | ({6'd0, code} << {ch, 1'b0});
    endfunction

    function automatic logic [BYTE_W-1:0] clear_or(input logic [BYTE_W-1:0] old,
                                                   input int unsigned pos,
                                                   input logic [BYTE_W-1:0] bits);
        return (old & ~(8'h01 << pos)) | bits;
    endfunction

endpackage

// File: rtl/pll_seq_step.sv
module pll_seq_step
    import pll_seq_pkg::*;
#(
    parameter logic [OFF_W-1:0] OFF_VCLK    = 6'd5,
    parameter logic [OFF_W-1:0] OFF_POST    = 6'd6,
    parameter logic [OFF_W-1:0] OFF_FB_BASE = 6'd7,
    parameter logic [OFF_W-1:0] OFF_EXT     = 6'd11,
    parameter logic [OFF_W-1:0] OFF_GEN     = 6'd2,
    parameter int unsigned      EXT_LSB     = 4,
    parameter int unsigned      VCLK_RST    = 2,
    parameter int unsigned      GEN_OVR     = 0,
    parameter int unsigned      GEN_MRST    = 1,
    parameter int unsigned      GEN_OSC     = 2
) (
    input  step_e             step,
    input  cfg_t              cfg,
    input  logic [BYTE_W-1:0] rd_q,
    output logic [OFF_W-1:0]  off,
    output logic [BYTE_W-1:0] wval
);
    localparam logic [BYTE_W-1:0] GEN_CLR = (8'h01 << GEN_OVR) | (8'h01 << GEN_MRST);
    localparam logic [BYTE_W-1:0] GEN_SET = 8'h01 << GEN_OSC;
    localparam logic [BYTE_W-1:0] RST_MSK = 8'h01 << VCLK_RST;

    always_comb begin
        off  = OFF_VCLK;
        wval = cfg.vclk;
        case (step)
            ST_VCLK_HOLD: begin
                off  = OFF_VCLK;
                wval = cfg.vclk;
            end
            ST_POST: begin
                off  = OFF_POST;
                wval = merge_pair(rd_q, cfg.chan, cfg.post);
            end
            ST_EXT: begin
                off  = OFF_EXT;
                wval = clear_or(rd_q, EXT_LSB + 32'(cfg.chan), cfg.ext);
            end
            ST_FB: begin
                off  = OFF_FB_BASE + {{(OFF_W-CH_W){1'b0}}, cfg.chan};
                wval = cfg.fb;
            end
            ST_GEN_MASK: begin
                off  = OFF_GEN;
                wval = (cfg.gen & ~GEN_CLR) | GEN_SET;
            end
            ST_VCLK_REL: begin
                off  = OFF_VCLK;
                wval = cfg.vclk & ~RST_MSK;
            end
            ST_GEN_FINAL: begin
                off  = OFF_GEN;
                wval = cfg.gen;
            end
            default: begin
                off  = OFF_VCLK;
                wval = cfg.vclk;
            end
        endcase
    end
endmodule

// File: rtl/pll_seq_bus.sv
module pll_seq_bus
    import pll_seq_pkg::*;
(
    input  phase_e            phase,
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTE_W-1:0] wval,
    output bus_word_t         word
);
    always_comb begin
        case (phase)
            PH_RADDR:  word = '{sel: 1'b0, we: 1'b1, data: addr_byte(off, 1'b0)};
            PH_RDATA:  word = '{sel: 1'b1, we: 1'b0, data: '0};
            PH_WADDR:  word = '{sel: 1'b0, we: 1'b1, data: addr_byte(off, 1'b1)};
            PH_WDATA:  word = '{sel: 1'b1, we: 1'b1, data: wval};
            PH_WCLOSE: word = '{sel: 1'b0, we: 1'b1, data: addr_byte(off, 1'b0)};
            default:   word = '{sel: 1'b0, we: 1'b1, data: addr_byte(off, 1'b0)};
        endcase
    end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cfg_t              cfg_in,
    input  logic              ack,
    input  logic [BYTE_W-1:0] rdata,
    input  bus_word_t         word,
    output step_e             step,
    output phase_e            phase,
    output cfg_t              cfg,
    output logic [BYTE_W-1:0] rd_q,
    output logic              run,
    output logic              done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            done  <= 1'b0;
            step  <= ST_VCLK_HOLD;
            phase <= PH_WADDR;
            cfg   <= '0;
            rd_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!run) begin
                if (start) begin
                    run   <= 1'b1;
                    cfg   <= cfg_in;
                    step  <= ST_VCLK_HOLD;
                    phase <= PH_WADDR;
                end
            end else if (ack) begin
                case (phase)
                    PH_RADDR: phase <= PH_RDATA;
                    PH_RDATA: begin
                        rd_q  <= rdata;
                        phase <= PH_WADDR;
                    end
                    PH_WADDR: phase <= PH_WDATA;
                    PH_WDATA: phase <= PH_WCLOSE;
                    PH_WCLOSE: begin
                        if (step == ST_GEN_FINAL) begin
                            run  <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            step  <= step_e'(step + 3'd1);
                            phase <= step_is_rmw(step_e'(step + 3'd1)) ? PH_RADDR : PH_WADDR;
                        end
                    end
                    default: phase <= PH_WADDR;
                endcase
            end
        end
    end

    // R10: an unaccepted access keeps its payload
    p_hold_payload_r10: assert property (@(posedge clk) disable iff (rst)
        (run && !ack) |=> (run && $stable(word)));

    // R12: completion is a single-cycle pulse with the sequencer idle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !run);

    // R11: captured configuration ignores a start while running
    p_cfg_locked_r11: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(cfg));

    // R2: a data write is always followed by the closing address access
    p_close_after_data_r2: assert property (@(posedge clk) disable iff (rst)
        (run && ack && phase == PH_WDATA) |=> (phase == PH_WCLOSE));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter logic [5:0] OFF_VCLK    = 6'd5,
    parameter logic [5:0] OFF_POST    = 6'd6,
    parameter logic [5:0] OFF_FB_BASE = 6'd7,
    parameter logic [5:0] OFF_EXT     = 6'd11,
    parameter logic [5:0] OFF_GEN     = 6'd2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] chan,
    input  logic [1:0] post_code,
    input  logic [7:0] ext_bits,
    input  logic [7:0] fb_div,
    input  logic [7:0] gen_ctl,
    input  logic [7:0] vclk_ctl,
    output logic       busy,
    output logic       done,
    output logic       bus_req,
    output logic       bus_sel,
    output logic       bus_we,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata,
    input  logic       bus_ack
);
    cfg_t              cfg_in, cfg;
    step_e             step;
    phase_e            phase;
    logic [BYTE_W-1:0] rd_q, wval;
    logic [OFF_W-1:0]  off;
    logic              run;
    bus_word_t         word;

    assign cfg_in = '{chan: chan, post: post_code, ext: ext_bits,
                      fb: fb_div, gen: gen_ctl, vclk: vclk_ctl};

    pll_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_in),
        .ack(bus_ack), .rdata(bus_rdata), .word(word),
        .step(step), .phase(phase), .cfg(cfg), .rd_q(rd_q),
        .run(run), .done(done)
    );

    pll_seq_step #(
        .OFF_VCLK(OFF_VCLK), .OFF_POST(OFF_POST), .OFF_FB_BASE(OFF_FB_BASE),
        .OFF_EXT(OFF_EXT), .OFF_GEN(OFF_GEN)
    ) u_step (
        .step(step), .cfg(cfg), .rd_q(rd_q), .off(off), .wval(wval)
    );

    pll_seq_bus u_bus (
        .phase(phase), .off(off), .wval(wval), .word(word)
    );

    assign busy      = run;
    assign bus_req   = run;
    assign bus_sel   = word.sel;
    assign bus_we    = word.we;
    assign bus_wdata = word.data;

    // R1: address bytes never carry bit 0
    p_addr_bit0_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_sel) |-> (bus_wdata[0] == 1'b0));
    // R12: no request outside a running sequence
    p_req_busy_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req);
endmodule

// File: tb/pll_reprog_seq_test.sv
module pll_reprog_seq_test;
    logic       clk = 0, rst = 1, start = 0;
    logic [1:0] chan = 0, post_code = 0;
    logic [7:0] ext_bits = 0, fb_div = 0, gen_ctl = 0, vclk_ctl = 0;
    logic       busy, done, bus_req, bus_sel, bus_we, bus_ack = 0;
    logic [7:0] bus_wdata, bus_rdata;

    always #2 clk = ~clk;

    pll_reprog_seq uut (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .post_code(post_code),
        .ext_bits(ext_bits), .fb_div(fb_div), .gen_ctl(gen_ctl), .vclk_ctl(vclk_ctl),
        .busy(busy), .done(done), .bus_req(bus_req), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int checks = 0, errors = 0;
    logic [7:0] regs [64];
    logic [7:0] addr_reg = 0;
    assign bus_rdata = regs[addr_reg[7:2]];

    logic       tr_sel [32], tr_we [32];
    logic [7:0] tr_dat [32];
    int         n_tr = 0;
    logic       ex_sel [32], ex_we [32];
    logic [7:0] ex_dat [32];
    string      ex_tag [32];
    int         n_ex = 0;
    int         ack_pct = 100, done_cnt = 0, done_bad = 0, stab_bad = 0;
    logic       pend = 0, psel = 0, pwe = 0, pdone = 0;
    logic [7:0] pdat = 0;
    int         cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        bus_ack = rst ? 1'b0 : (($urandom % 100) < ack_pct);
        if (pend && bus_req && (bus_sel != psel || bus_we != pwe || bus_wdata != pdat))
            stab_bad++;
        if (done) begin
            done_cnt++;
            if (busy || pdone) done_bad++;
        end
        pdone = done;
        if (bus_req && bus_ack && n_tr < 32) begin
            tr_sel[n_tr] = bus_sel;
            tr_we[n_tr]  = bus_we;
            tr_dat[n_tr] = (bus_sel && !bus_we) ? regs[addr_reg[7:2]] : bus_wdata;
            n_tr++;
            if (!bus_sel) addr_reg = bus_wdata;
            else if (bus_we && addr_reg[1]) regs[addr_reg[7:2]] = bus_wdata;
        end
        pend = bus_req && !bus_ack;
        psel = bus_sel; pwe = bus_we; pdat = bus_wdata;
    end

    function automatic logic [7:0] ab(input int off, input bit w);
        return 8'((off << 2) | (w ? 2 : 0));
    endfunction

    task automatic push(input bit s, input bit w, input logic [7:0] d, input string t);
        ex_sel[n_ex] = s; ex_we[n_ex] = w; ex_dat[n_ex] = d; ex_tag[n_ex] = t; n_ex++;
    endtask

    task automatic push_wr(input int off, input logic [7:0] v, input string t);
        push(0, 1, ab(off, 1), t); push(1, 1, v, t); push(0, 1, ab(off, 0), t);
    endtask

    task automatic push_rd(input int off, input logic [7:0] v);
        push(0, 1, ab(off, 0), "R3"); push(1, 0, v, "R3");
    endtask

    task automatic run_seq(input logic [1:0] c, input logic [1:0] p, input logic [7:0] e,
                           input logic [7:0] f, input logic [7:0] g, input logic [7:0] v,
                           input int ackp, input bit inject);
        logic [7:0] npost, next_, ngen;
        npost = (regs[6] & ~(8'h03 << (2*c))) | (8'(p) << (2*c));
        next_ = (regs[11] & ~(8'h01 << (4+c))) | e;
        ngen  = (g & 8'hFC) | 8'h04;
        n_ex = 0;
        push_wr(5, v, "R9");
        push_rd(6, regs[6]);  push_wr(6, npost, "R5");
        push_rd(11, regs[11]); push_wr(11, next_, "R6");
        push_wr(7 + c, f, "R7");
        push_wr(2, ngen, "R8");
        push_wr(5, v & 8'hFB, "R9");
        push_wr(2, g, "R8");
        @(negedge clk);
        n_tr = 0; done_cnt = 0; done_bad = 0; stab_bad = 0; ack_pct = ackp;
        chan = c; post_code = p; ext_bits = e; fb_div = f; gen_ctl = g; vclk_ctl = v;
        start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 3000; i++) begin
            if (inject && i == 6) begin
                chan = ~c; post_code = ~p; ext_bits = ~e; fb_div = ~f; gen_ctl = ~g; vclk_ctl = ~v;
                start = 1;
            end else start = 0;
            if (done) break;
            @(negedge clk);
        end
        start = 0;
        repeat (6) @(negedge clk);
        chk(n_tr == 25, "R2 access count", n_tr, 25);
        if (inject) chk(n_tr == 25, "R11 no second sequence", n_tr, 25);
        for (int i = 0; i < 25 && i < n_tr; i++) begin
            chk(tr_sel[i] == ex_sel[i] && tr_we[i] == ex_we[i] && tr_dat[i] == ex_dat[i],
                $sformatf("%s access %0d", ex_tag[i], i),
                {tr_sel[i], tr_we[i], tr_dat[i]}, {ex_sel[i], ex_we[i], ex_dat[i]});
            if (!tr_sel[i]) chk(tr_dat[i][0] == 1'b0 && tr_we[i], "R1 address format", tr_dat[i], ex_dat[i]);
        end
        chk(regs[6] == npost, "R4 final post", regs[6], npost);
        chk(regs[11] == next_, "R4 final ext", regs[11], next_);
        chk(regs[7+c] == f, "R4 final fb", regs[7+c], f);
        chk(regs[2] == g, "R4 final gen", regs[2], g);
        chk(regs[5] == (v & 8'hFB), "R4 final vclk", regs[5], v & 8'hFB);
        chk(stab_bad == 0, "R10 payload stable", stab_bad, 0);
        chk(done_cnt == 1 && done_bad == 0, "R12 done pulse", done_cnt, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) regs[i] = 8'($urandom);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!bus_req && !busy && !done, "R12 reset state", {bus_req, busy, done}, 0);
        for (int c = 0; c < 4; c++)
            run_seq(2'(c), 2'(c), 8'h00, 8'hA5 + 8'(c), 8'hFF, 8'hFF, 100, 0);
        run_seq(2'd2, 2'd0, 8'hFF, 8'h80, 8'h00, 8'h00, 100, 0);
        run_seq(2'd1, 2'd3, 8'h0F, 8'hFF, 8'h3C, 8'h04, 40, 0);
        run_seq(2'd3, 2'd1, 8'h22, 8'h90, 8'hC3, 8'h7E, 60, 1);
        for (int k = 0; k < 20; k++)
            run_seq(2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
                    8'($urandom), 8'($urandom), 30 + ($urandom % 71), k % 5 == 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule